// File: doc/BRIEF.md
# Configurable Parallel CRC Engine

This block keeps a running 16-bit or 32-bit cyclic redundancy checksum and folds a whole input word into it on every clock edge that carries valid data. The per-bit serial shift of a linear feedback register is unrolled into combinational next-state logic, so an 8, 16 or 32-bit word costs one cycle whatever its width. Two generator polynomials are built in: the 16-bit 0x1021 (x^16 + x^12 + x^5 + 1) and the 32-bit 0x04C11DB7 used by Ethernet.

Before a message, the host selects the polynomial size, the input word width and the bit order through a configuration write. It then writes a start value into the checksum register and streams data words. The checksum register is visible on the output at all times. No final inversion or reflection is applied, so the output is the raw register contents.

Top module: `crc_engine`

## Requirements
- R1: While reset is active and after it is released, the configuration is all zero (16-bit polynomial, 8-bit words, least-significant-bit first) and `crc_o` reads 0x0000FFFF, because the checksum register is all ones.
- R2: With the 16-bit polynomial, most-significant-bit first and 8-bit words, a start value of 0xFFFF and the ASCII bytes "123456789" give `crc_o` = 0x000029B1. This shows that no final XOR is applied.
- R3: With the 32-bit polynomial, least-significant-bit first, 8-bit words and a start value of 0xFFFFFFFF, the same bytes give `crc_o` = 0x340BC6D9. Least-significant-bit first means a right-shifting register with the bit-reversed polynomial.
- R4: With the 16-bit polynomial, least-significant-bit first, 8-bit words and a start value of 0xFFFF, the same bytes give `crc_o` = 0x00006F91.
- R5: With the 32-bit polynomial, most-significant-bit first, 8-bit words and a start value of 0xFFFFFFFF, the same bytes give `crc_o` = 0x0376E6E7.
- R6: `cfg_width_i` selects the word width: 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. Every word is absorbed in the cycle it is offered, as if its bits went one by one through the serial register (bit 0 first when LSB-first, the top used bit first when MSB-first). Data bits above the selected width have no effect.
- R7: When `data_valid_i` and `seed_we_i` are both low, `crc_o` holds its value whatever `data_i` carries. This holds as long as no configuration write changes the polynomial size.
- R8: When `seed_we_i` is high, the register takes `seed_i` on that edge, and any word offered in the same cycle is discarded.
- R9: When the 16-bit polynomial is selected, only `seed_i[15:0]` and register bits 15:0 are used, and `crc_o[31:16]` reads zero.
- R10: A configuration write with `cfg_we_i` high takes effect for words offered from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we_i | input | 1 | Write strobe for the three configuration fields |
| cfg_wide_i | input | 1 | 1 selects the 32-bit polynomial, 0 selects the 16-bit polynomial |
| cfg_width_i | input | 2 | Input word width code (0: 8, 1: 16, 2 or 3: 32 bits) |
| cfg_msb_first_i | input | 1 | 1 feeds data most-significant-bit first, 0 feeds least-significant-bit first |
| seed_we_i | input | 1 | Loads `seed_i` into the checksum register |
| seed_i | input | 32 | Start value |
| data_valid_i | input | 1 | Qualifies `data_i` for absorption this cycle |
| data_i | input | 32 | Input word, right-aligned |
| crc_o | output | 32 | Current checksum register, upper half zero in 16-bit mode |

## Verification
Every absorbed word changes the register through a bijective map, so a wrong bit in the state shows on `crc_o` one cycle later and stays visible for the rest of the message. An error in a single feedback tap or in the bit order changes the check values for the standard nine-byte string immediately. The scoreboard compares `crc_o` against a bit-serial model after every cycle it drives, so a divergence is reported at the cycle where it first appears rather than at the end of a message. Idle cycles with toggling data and same-cycle seed and data cycles show faults in the enable and the load priority within one cycle.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int unsigned CRC_MAX_W = 32;
  localparam int unsigned CRC_MIN_W = 16;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned N_WIDTHS  = 3;
  localparam int unsigned WSEL_W    = 2;

  localparam logic [CRC_MAX_W-1:0] POLY_WIDE   = 32'h04C1_1DB7;
  localparam logic [CRC_MIN_W-1:0] POLY_NARROW = 16'h1021;

  typedef enum logic [WSEL_W-1:0] {
    WORD_8  = 2'd0,
    WORD_16 = 2'd1,
    WORD_32 = 2'd2,
    WORD_XX = 2'd3
  } word_w_e;

  typedef struct packed {
    logic    wide;
    word_w_e width;
    logic    msb_first;
  } crc_cfg_t;

  // Reverse the lowest n bits of v.
  function automatic logic [31:0] bit_rev(input logic [31:0] v, input int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) r[i] = v[n-1-i];
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_lane.sv
// Unrolled serial LFSR: absorbs DW data bits into a CW-bit register.
module crc_lane #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 16,
  parameter logic [CW-1:0] POLY = '1
) (
  input  logic [CW-1:0] crc_i,
  input  logic [DW-1:0] data_i,
  input  logic          msb_first_i,
  output logic [CW-1:0] crc_nxt_o
);

  localparam logic [31:0]   POLY_EXT = 32'(POLY);
  localparam logic [CW-1:0] POLY_REV = CW'(crc_pkg::bit_rev(POLY_EXT, CW));

  logic [CW-1:0] acc;
  logic          fb;

  always_comb begin
    acc = crc_i;
    fb  = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (msb_first_i) begin
        fb  = acc[CW-1] ^ data_i[DW-1-i];
        acc = {acc[CW-2:0], 1'b0};
        if (fb) acc = acc ^ POLY;
      end else begin
        fb  = acc[0] ^ data_i[i];
        acc = acc >> 1;
        if (fb) acc = acc ^ POLY_REV;
      end
    end
    crc_nxt_o = acc;
  end

endmodule

// File: rtl/crc_next.sv
// Next-state selection across polynomial size and word width.
module crc_next
  import crc_pkg::*;
(
  input  logic [CRC_MAX_W-1:0] crc_i,
  input  logic [DATA_W-1:0]    data_i,
  input  crc_cfg_t             cfg_i,
  output logic [CRC_MAX_W-1:0] crc_nxt_o
);

  logic [CRC_MAX_W-1:0] nxt_wide   [N_WIDTHS];
  logic [CRC_MIN_W-1:0] nxt_narrow [N_WIDTHS];
  logic [1:0]           wsel;

  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
    localparam int unsigned DW = 8 << g;

    crc_lane #(.DW(DW), .CW(CRC_MAX_W), .POLY(POLY_WIDE)) u_wide (
      .crc_i       (crc_i),
      .data_i      (data_i[DW-1:0]),
      .msb_first_i (cfg_i.msb_first),
      .crc_nxt_o   (nxt_wide[g])
    );

    crc_lane #(.DW(DW), .CW(CRC_MIN_W), .POLY(POLY_NARROW)) u_narrow (
      .crc_i       (crc_i[CRC_MIN_W-1:0]),
      .data_i      (data_i[DW-1:0]),
      .msb_first_i (cfg_i.msb_first),
      .crc_nxt_o   (nxt_narrow[g])
    );
  end

  always_comb begin
    wsel = (cfg_i.width == WORD_XX) ? 2'd2 : 2'(cfg_i.width);
    if (cfg_i.wide) crc_nxt_o = nxt_wide[wsel];
    else            crc_nxt_o = {{(CRC_MAX_W-CRC_MIN_W){1'b0}}, nxt_narrow[wsel]};
  end

endmodule

// File: rtl/crc_cfg_reg.sv
module crc_cfg_reg
  import crc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  crc_cfg_t cfg_i,
  output crc_cfg_t cfg_o
);

  crc_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg
  import crc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 seed_we_i,
  input  logic [CRC_MAX_W-1:0] seed_i,
  input  logic                 valid_i,
  input  logic [CRC_MAX_W-1:0] crc_nxt_i,
  output logic [CRC_MAX_W-1:0] crc_o
);

  logic [CRC_MAX_W-1:0] crc_d, crc_q;
  logic                 crc_en;

  always_comb begin
    crc_en = seed_we_i | valid_i;
    crc_d  = seed_we_i ? seed_i : crc_nxt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic        cfg_wide_i,
  input  logic [1:0]  cfg_width_i,
  input  logic        cfg_msb_first_i,
  input  logic        seed_we_i,
  input  logic [31:0] seed_i,
  input  logic        data_valid_i,
  input  logic [31:0] data_i,
  output logic [31:0] crc_o
);

  logic                 rst_meta_q, rst_n_sync;
  crc_cfg_t             cfg_wr, cfg_q;
  logic [CRC_MAX_W-1:0] crc_q, crc_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  always_comb begin
    cfg_wr.wide      = cfg_wide_i;
    cfg_wr.width     = word_w_e'(cfg_width_i);
    cfg_wr.msb_first = cfg_msb_first_i;
  end

  crc_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .we_i   (cfg_we_i),
    .cfg_i  (cfg_wr),
    .cfg_o  (cfg_q)
  );

  crc_next u_next (
    .crc_i     (crc_q),
    .data_i    (data_i),
    .cfg_i     (cfg_q),
    .crc_nxt_o (crc_nxt)
  );

  crc_state_reg u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .seed_we_i (seed_we_i),
    .seed_i    (seed_i),
    .valid_i   (data_valid_i),
    .crc_nxt_i (crc_nxt),
    .crc_o     (crc_q)
  );

  assign crc_o = cfg_q.wide ? crc_q : {{(CRC_MAX_W-CRC_MIN_W){1'b0}}, crc_q[CRC_MIN_W-1:0]};

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk (
  input logic        clk_i,
  input logic        rst_n,
  input logic        cfg_we_i,
  input logic        cfg_wide_i,
  input logic        seed_we_i,
  input logic [31:0] seed_i,
  input logic        data_valid_i,
  input logic        wide_q,
  input logic [31:0] crc_o
);

  // R7
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!data_valid_i && !seed_we_i && !cfg_we_i) |=> $stable(crc_o));

  // R8
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (seed_we_i && !cfg_we_i) |=>
      crc_o == (wide_q ? $past(seed_i) : {16'h0, $past(seed_i[15:0])}));

  // R9
  narrow_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wide_q |-> crc_o[31:16] == 16'h0);

  // R10
  cfg_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_we_i |=> wide_q == $past(cfg_wide_i));

endmodule

bind crc_engine crc_engine_chk u_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_n_sync),
  .cfg_we_i     (cfg_we_i),
  .cfg_wide_i   (cfg_wide_i),
  .seed_we_i    (seed_we_i),
  .seed_i       (seed_i),
  .data_valid_i (data_valid_i),
  .wide_q       (cfg_q.wide),
  .crc_o        (crc_o)
);

// File: tb/crc_engine_tb_top.sv
`timescale 1ns/1ps
module crc_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_wide, cfg_msb, seed_we, valid;
  logic [1:0]  cfg_width;
  logic [31:0] seed, data, crc;

  always #2.5 clk = ~clk;

  crc_engine dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .cfg_we_i (cfg_we), .cfg_wide_i (cfg_wide), .cfg_width_i (cfg_width),
    .cfg_msb_first_i (cfg_msb), .seed_we_i (seed_we), .seed_i (seed),
    .data_valid_i (valid), .data_i (data), .crc_o (crc)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  // model state
  logic [31:0] m_crc;
  logic        m_wide, m_msb;
  logic [1:0]  m_width;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected < 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: compare due items on falling edges
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      void'(due_q.pop_front());
      check(tag_q.pop_front(), crc, exp_q.pop_front());
    end
  end

  function automatic logic [31:0] mstep(input logic [31:0] c, input logic [31:0] d,
                                        input logic w, input logic [1:0] wc, input logic msb);
    int n;
    logic b, fb;
    n = (wc == 2'd0) ? 8 : (wc == 2'd1) ? 16 : 32;
    if (!w) c[31:16] = 16'h0;
    for (int i = 0; i < n; i++) begin
      b = msb ? d[n-1-i] : d[i];
      if (w) begin
        if (msb) begin fb = c[31] ^ b; c = c << 1; if (fb) c ^= 32'h04C11DB7; end
        else     begin fb = c[0]  ^ b; c = c >> 1; if (fb) c ^= 32'hEDB88320; end
      end else begin
        if (msb) begin fb = c[15] ^ b; c = {16'h0, c[14:0], 1'b0}; if (fb) c ^= 32'h1021; end
        else     begin fb = c[0]  ^ b; c = c >> 1;                 if (fb) c ^= 32'h8408; end
      end
    end
    return c;
  endfunction

  function automatic logic [31:0] mview();
    return m_wide ? m_crc : {16'h0, m_crc[15:0]};
  endfunction

  // driver: one cycle per call, expected result scored one cycle later
  task automatic drive(input string tag, input logic cw, input logic w, input logic [1:0] wc,
                       input logic m, input logic sw, input logic [31:0] s,
                       input logic v, input logic [31:0] d);
    @(negedge clk);
    cfg_we = cw; cfg_wide = w; cfg_width = wc; cfg_msb = m;
    seed_we = sw; seed = s; valid = v; data = d;
    if (sw)     m_crc = s;
    else if (v) m_crc = mstep(m_crc, d, m_wide, m_width, m_msb);
    if (cw) begin m_wide = w; m_width = wc; m_msb = m; end
    exp_q.push_back(mview()); due_q.push_back(cyc + 1); tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag, input logic [31:0] d);
    drive(tag, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, d);
  endtask

  task automatic setup(input string tag, input logic w, input logic [1:0] wc, input logic m,
                       input logic [31:0] s);
    drive(tag, 1'b1, w, wc, m, 1'b0, 32'h0, 1'b0, 32'h0);
    drive(tag, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, s, 1'b0, 32'h0);
  endtask

  task automatic feed(input string tag, input logic [31:0] d);
    drive(tag, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 1'b1, d);
  endtask

  task automatic digits(input string tag, input logic [31:0] junk);
    for (int i = 1; i <= 9; i++) feed(tag, (junk & 32'hFFFFFF00) | (32'h30 + i));
  endtask

  task automatic drain();
    idle("drain", 32'h0);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; cfg_wide = 0; cfg_width = 0; cfg_msb = 0;
    seed_we = 0; seed = 0; valid = 0; data = 0;
    m_crc = 32'hFFFFFFFF; m_wide = 0; m_width = 0; m_msb = 0;
    repeat (4) @(negedge clk);
    check("R1 in reset", crc, 32'h0000FFFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", crc, 32'h0000FFFF);

    setup("R2", 1'b0, 2'd0, 1'b1, 32'h0000FFFF);
    digits("R2", 32'h0);
    drain(); check("R2 check value", crc, 32'h000029B1);

    setup("R4", 1'b0, 2'd0, 1'b0, 32'h0000FFFF);
    digits("R4", 32'hA5A5A500);
    drain(); check("R4 check value", crc, 32'h00006F91);

    setup("R3", 1'b1, 2'd0, 1'b0, 32'hFFFFFFFF);
    digits("R3", 32'h5A5A5A00);
    drain(); check("R3 check value", crc, 32'h340BC6D9);

    setup("R5", 1'b1, 2'd0, 1'b1, 32'hFFFFFFFF);
    digits("R5", 32'h0);
    drain(); check("R5 check value", crc, 32'h0376E6E7);

    // R6: 32-bit word LSB-first equals bytes little-endian
    setup("R6 w32", 1'b1, 2'd2, 1'b0, 32'hFFFFFFFF);
    feed("R6 w32", 32'h34333231);
    feed("R6 w32", 32'h38373635);
    drive("R6 w8", 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
    feed("R6 w8", 32'hFFFFFF39);
    drain(); check("R6 mixed widths", crc, 32'h340BC6D9);

    // R6: 16-bit words MSB-first, upper data bits junk; code 3 acts as 32
    setup("R6 w16", 1'b0, 2'd1, 1'b1, 32'h0000FFFF);
    for (int i = 0; i < 6; i++) feed("R6 w16 junk", {16'hDEAD + 16'(i), 16'h1234 * 16'(i + 1)});
    setup("R6 code3", 1'b1, 2'd3, 1'b1, 32'h12345678);
    for (int i = 0; i < 4; i++) feed("R6 code3", 32'h9E3779B9 * (i + 1));

    // R7: idle with toggling data
    for (int i = 0; i < 6; i++) idle("R7 hold", 32'hFFFF0000 ^ (32'h01010101 * i));

    // R8: seed wins over same-cycle data
    drive("R8 seed+data", 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'hCAFEF00D, 1'b1, 32'hFFFFFFFF);
    idle("R8 hold", 32'h0);

    // R9: narrow mode masks seed upper half
    drive("R9 cfg", 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
    drive("R9 seed", 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'hABCD1234, 1'b0, 32'h0);
    feed("R9 data", 32'h87654321);

    // R10: config write and data in same cycle use old config
    drive("R10 cfg+data", 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 32'h0, 1'b1, 32'h0BADBEEF);
    feed("R10 new cfg", 32'h000000C3);

    // mixed random traffic (R6 R7 R8 R10)
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r == 0)      drive("R10 rand cfg", 1'b1, 1'($urandom), 2'($urandom), 1'($urandom),
                             1'b0, 32'h0, 1'($urandom), $urandom);
      else if (r == 1) drive("R8 rand seed", 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, $urandom,
                             1'($urandom), $urandom);
      else if (r == 2) idle("R7 rand idle", $urandom);
      else             feed("R6 rand data", $urandom);
    end
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule